// File: doc/BRIEF.md
# Deferred-Blend Tile Destination Buffer

This block sits between a renderer that emits pixels in arbitrary screen order and the framebuffer memory. While a tile is being drawn, every incoming pixel lands in an on-chip square of 16x16 slots addressed by tile-relative coordinates. Each slot keeps a color, an 8-bit coverage/opacity value and a written mark. A later pixel aimed at the same slot simply replaces the earlier one, so overdraw never produces intermediate blends.

When the renderer issues a flush carrying the tile's screen origin, the block walks the tile one row at a time. For each row it requests a read burst of the framebuffer row, mixes each returning beat with the matching slot (only if that slot was written), and holds the row in a small line buffer. It then issues a write burst of the same length to the same address. Translucency is therefore applied exactly once per screen pixel, against the final tile contents. Pixel input is refused for the whole flush. A one-cycle completion pulse marks the end, and all written marks are cleared at that moment.

Top module: `tdb_tile_buffer`

## Requirements
- R1: While idle (`pix_ready` high), a pixel offered with `pix_valid` is stored at slot (`pix_x`, `pix_y`). A later pixel to the same slot fully replaces the earlier color and alpha.
- R2: `pix_ready` and `flush_ready` are low from the cycle after a flush is accepted until the cycle after the final write beat of that flush is accepted. No pixel is taken in that window.
- R3: A flush handles rows 0 to 15 in order. Each row uses: one read command at address (origin_y + row) * 2^FB_X_W + origin_x; 16 read beats; one write command to the same address; and 16 write beats. `wr_last` is high only on the 16th write beat.
- R4: A slot not written since the previous flush is written back with the exact value read from the framebuffer.
- R5: For a written slot with alpha a, each 8-bit channel (blue in bits 7:0, green in 15:8, red in 23:16) is written as the nearest integer to (src*a + dst*(255-a)) / 255.
- R6: Alpha 255 writes the source color unchanged and alpha 0 writes the framebuffer color unchanged.
- R7: `flush_done` is high for exactly one cycle, in the cycle right after the final write beat is accepted, and the block is idle in that cycle.
- R8: All written marks clear at flush completion. A following flush with no new pixels writes every framebuffer value back unchanged.
- R9: A pixel and a flush offered in the same idle cycle are both accepted, and that pixel takes part in that flush.
- R10: A command or write beat held by a low ready keeps its valid high and its address, data and last flag unchanged.
- R11: During reset `pix_ready` and `flush_ready` are high, and `flush_done`, `rd_cmd_valid`, `wr_cmd_valid` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted when high with valid |
| pix_x | input | TILE_LOG2 (4) | Tile-relative column |
| pix_y | input | TILE_LOG2 (4) | Tile-relative row |
| pix_color | input | 24 | Source color, three 8-bit channels |
| pix_alpha | input | 8 | Source opacity |
| flush_valid | input | 1 | Flush requested |
| flush_ready | output | 1 | Flush accepted when high with valid |
| flush_org_x | input | FB_X_W (10) | Screen column of tile origin |
| flush_org_y | input | FB_Y_W (10) | Screen row of tile origin |
| flush_done | output | 1 | One-cycle completion pulse |
| rd_cmd_valid | output | 1 | Read burst request |
| rd_cmd_ready | input | 1 | Memory accepts read request |
| rd_cmd_addr | output | FB_X_W+FB_Y_W (20) | Read burst start address |
| rd_valid | input | 1 | Read beat present |
| rd_data | input | 24 | Read beat color |
| wr_cmd_valid | output | 1 | Write burst request |
| wr_cmd_ready | input | 1 | Memory accepts write request |
| wr_cmd_addr | output | FB_X_W+FB_Y_W (20) | Write burst start address |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory accepts write beat |
| wr_data | output | 24 | Write beat color |
| wr_last | output | 1 | Final beat of write burst |

## Verification
The delicate overlap is a pixel write and a flush start landing on the same idle clock edge. The stored pixel must then already be part of the tile being flushed, and the input must close on the next cycle. The bench raises both valids together, checks that both handshakes complete in that one cycle, and then checks that the later write beat for that slot carries the new source color. A second pixel is held at the input across the whole flush. It must stay refused until the completion pulse and then be accepted, which the per-cycle comparison of `pix_ready` and the following flush both judge.

// File: rtl/tdb_pkg.sv
package tdb_pkg;

    localparam int CH_W   = 8;
    localparam int NUM_CH = 3;
    localparam int PX_W   = CH_W * NUM_CH;

    typedef logic [CH_W-1:0] ch_t;
    typedef logic [PX_W-1:0] px_t;

    typedef struct packed {
        px_t color;
        ch_t alpha;
    } slot_t;

    typedef enum logic [2:0] {
        FL_IDLE,
        FL_RD_CMD,
        FL_RD_DATA,
        FL_WR_CMD,
        FL_WR_DATA
    } fl_state_t;

    // Weighted mix divided by the channel maximum, rounded to nearest,
    // using an add-and-shift in place of a true divide.
    function automatic ch_t mix_ch(input ch_t src, input ch_t dst, input ch_t a);
        logic [2*CH_W+1:0] s_w;
        logic [2*CH_W+1:0] d_w;
        logic [2*CH_W+1:0] a_w;
        logic [2*CH_W+1:0] na_w;
        logic [2*CH_W+1:0] half;
        logic [2*CH_W+1:0] acc;
        s_w  = {{(CH_W+2){1'b0}}, src};
        d_w  = {{(CH_W+2){1'b0}}, dst};
        a_w  = {{(CH_W+2){1'b0}}, a};
        na_w = {{(CH_W+2){1'b0}}, ~a};   // max - a
        half = '0;
        half[CH_W-1] = 1'b1;
        acc = s_w * a_w + d_w * na_w + half;
        acc = acc + (acc >> CH_W);
        return acc[2*CH_W-1:CH_W];
    endfunction

endpackage

// File: rtl/tdb_tile_store.sv
module tdb_tile_store
    import tdb_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_slot,
    output logic             rd_written
);
    localparam int DEPTH = 1 << IDX_W;

    slot_t            slots [DEPTH];
    logic [DEPTH-1:0] marks;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_slot;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            marks <= '0;
        end else if (wr_en) begin
            marks[wr_idx] <= 1'b1;
        end
    end

    assign rd_slot    = slots[rd_idx];
    assign rd_written = marks[rd_idx];

endmodule

// File: rtl/tdb_blend.sv
module tdb_blend
    import tdb_pkg::*;
(
    input  slot_t src,
    input  logic  use_src,
    input  px_t   dst,
    output px_t   result
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_t mixed;
        assign mixed = mix_ch(src.color[c*CH_W +: CH_W], dst[c*CH_W +: CH_W], src.alpha);
        assign result[c*CH_W +: CH_W] = use_src ? mixed : dst[c*CH_W +: CH_W];
    end

endmodule

// File: rtl/tdb_flush_ctrl.sv
module tdb_flush_ctrl
    import tdb_pkg::*;
#(
    parameter int TILE_LOG2 = 4,
    parameter int FB_X_W    = 10,
    parameter int FB_Y_W    = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush_valid,
    input  logic [FB_X_W-1:0]        org_x,
    input  logic [FB_Y_W-1:0]        org_y,
    output logic                     idle,
    output logic [2*TILE_LOG2-1:0]   tile_idx,
    input  px_t                      mix_px,
    output logic                     rd_cmd_valid,
    input  logic                     rd_cmd_ready,
    input  logic                     rd_valid,
    output logic                     wr_cmd_valid,
    input  logic                     wr_cmd_ready,
    output logic [FB_X_W+FB_Y_W-1:0] cmd_addr,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output px_t                      wr_data,
    output logic                     wr_last,
    output logic                     clr_all,
    output logic                     flush_done
);
    localparam int TILE = 1 << TILE_LOG2;
    localparam logic [TILE_LOG2-1:0] LAST = '1;

    fl_state_t            state;
    logic [TILE_LOG2-1:0] row;
    logic [TILE_LOG2-1:0] col;
    logic [FB_X_W-1:0]    base_x;
    logic [FB_Y_W-1:0]    base_y;
    logic [FB_Y_W-1:0]    row_y;
    px_t                  line [TILE];
    logic                 beat_out;
    logic                 tile_end;

    assign beat_out = (state == FL_WR_DATA) && wr_ready;
    assign tile_end = beat_out && (col == LAST) && (row == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= FL_IDLE;
            row        <= '0;
            col        <= '0;
            base_x     <= '0;
            base_y     <= '0;
            flush_done <= 1'b0;
        end else begin
            flush_done <= 1'b0;
            unique case (state)
                FL_IDLE: begin
                    if (flush_valid) begin
                        base_x <= org_x;
                        base_y <= org_y;
                        row    <= '0;
                        col    <= '0;
                        state  <= FL_RD_CMD;
                    end
                end
                FL_RD_CMD: begin
                    if (rd_cmd_ready) state <= FL_RD_DATA;
                end
                FL_RD_DATA: begin
                    if (rd_valid) begin
                        col <= col + 1'b1;
                        if (col == LAST) state <= FL_WR_CMD;
                    end
                end
                FL_WR_CMD: begin
                    if (wr_cmd_ready) state <= FL_WR_DATA;
                end
                FL_WR_DATA: begin
                    if (wr_ready) begin
                        col <= col + 1'b1;
                        if (col == LAST) begin
                            if (row == LAST) begin
                                state      <= FL_IDLE;
                                flush_done <= 1'b1;
                            end else begin
                                row   <= row + 1'b1;
                                state <= FL_RD_CMD;
                            end
                        end
                    end
                end
                default: state <= FL_IDLE;
            endcase
        end
    end

    // Row staging: each read beat is mixed on arrival and parked here.
    always_ff @(posedge clk) begin
        if (state == FL_RD_DATA && rd_valid) begin
            line[col] <= mix_px;
        end
    end

    assign row_y        = base_y + {{(FB_Y_W-TILE_LOG2){1'b0}}, row};
    assign cmd_addr     = {row_y, base_x};
    assign tile_idx     = {row, col};
    assign idle         = (state == FL_IDLE);
    assign rd_cmd_valid = (state == FL_RD_CMD);
    assign wr_cmd_valid = (state == FL_WR_CMD);
    assign wr_valid     = (state == FL_WR_DATA);
    assign wr_data      = line[col];
    assign wr_last      = wr_valid && (col == LAST);
    assign clr_all      = tile_end;

endmodule

// File: rtl/tdb_tile_buffer.sv
module tdb_tile_buffer
    import tdb_pkg::*;
#(
    parameter int TILE_LOG2 = 4,
    parameter int FB_X_W    = 10,
    parameter int FB_Y_W    = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pix_valid,
    output logic                     pix_ready,
    input  logic [TILE_LOG2-1:0]     pix_x,
    input  logic [TILE_LOG2-1:0]     pix_y,
    input  logic [PX_W-1:0]          pix_color,
    input  logic [CH_W-1:0]          pix_alpha,
    input  logic                     flush_valid,
    output logic                     flush_ready,
    input  logic [FB_X_W-1:0]        flush_org_x,
    input  logic [FB_Y_W-1:0]        flush_org_y,
    output logic                     flush_done,
    output logic                     rd_cmd_valid,
    input  logic                     rd_cmd_ready,
    output logic [FB_X_W+FB_Y_W-1:0] rd_cmd_addr,
    input  logic                     rd_valid,
    input  logic [PX_W-1:0]          rd_data,
    output logic                     wr_cmd_valid,
    input  logic                     wr_cmd_ready,
    output logic [FB_X_W+FB_Y_W-1:0] wr_cmd_addr,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output logic [PX_W-1:0]          wr_data,
    output logic                     wr_last
);
    localparam int IDX_W = 2 * TILE_LOG2;
    localparam int AW    = FB_X_W + FB_Y_W;

    logic             idle;
    logic             store_we;
    slot_t            in_slot;
    slot_t            cur_slot;
    logic             cur_written;
    logic [IDX_W-1:0] walk_idx;
    logic             clr_all;
    px_t              mix_px;
    logic [AW-1:0]    cmd_addr;

    assign pix_ready       = idle;
    assign flush_ready     = idle;
    assign store_we        = pix_valid && idle;
    assign in_slot.color   = pix_color;
    assign in_slot.alpha   = pix_alpha;

    tdb_tile_store #(.IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (store_we),
        .wr_idx     ({pix_y, pix_x}),
        .wr_slot    (in_slot),
        .clr_all    (clr_all),
        .rd_idx     (walk_idx),
        .rd_slot    (cur_slot),
        .rd_written (cur_written)
    );

    tdb_blend u_blend (
        .src     (cur_slot),
        .use_src (cur_written),
        .dst     (rd_data),
        .result  (mix_px)
    );

    tdb_flush_ctrl #(
        .TILE_LOG2 (TILE_LOG2),
        .FB_X_W    (FB_X_W),
        .FB_Y_W    (FB_Y_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .flush_valid  (flush_valid),
        .org_x        (flush_org_x),
        .org_y        (flush_org_y),
        .idle         (idle),
        .tile_idx     (walk_idx),
        .mix_px       (mix_px),
        .rd_cmd_valid (rd_cmd_valid),
        .rd_cmd_ready (rd_cmd_ready),
        .rd_valid     (rd_valid),
        .wr_cmd_valid (wr_cmd_valid),
        .wr_cmd_ready (wr_cmd_ready),
        .cmd_addr     (cmd_addr),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_data      (wr_data),
        .wr_last      (wr_last),
        .clr_all      (clr_all),
        .flush_done   (flush_done)
    );

    assign rd_cmd_addr = cmd_addr;
    assign wr_cmd_addr = cmd_addr;

endmodule

// File: rtl/tdb_tile_buffer_chk.sv
module tdb_tile_buffer_chk #(
    parameter int AW   = 20,
    parameter int PX_W = 24
) (
    input logic            clk,
    input logic            rst,
    input logic            pix_ready,
    input logic            flush_valid,
    input logic            flush_ready,
    input logic            flush_done,
    input logic            rd_cmd_valid,
    input logic            rd_cmd_ready,
    input logic [AW-1:0]   rd_cmd_addr,
    input logic            wr_cmd_valid,
    input logic            wr_cmd_ready,
    input logic [AW-1:0]   wr_cmd_addr,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [PX_W-1:0] wr_data,
    input logic            wr_last
);
    assert_closed_after_flush_R2: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_ready) |=> (!pix_ready && !flush_ready));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> (pix_ready && flush_ready));

    assert_last_in_beat_R3: assert property (@(posedge clk) disable iff (rst)
        wr_last |-> wr_valid);

    assert_one_request_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_cmd_valid, wr_cmd_valid, wr_valid}));

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_last)));

    assert_rd_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd_valid && !rd_cmd_ready) |=> (rd_cmd_valid && $stable(rd_cmd_addr)));

    assert_wr_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd_valid && !wr_cmd_ready) |=> (wr_cmd_valid && $stable(wr_cmd_addr)));

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (pix_ready && !flush_done && !rd_cmd_valid && !wr_cmd_valid && !wr_valid));

endmodule

bind tdb_tile_buffer tdb_tile_buffer_chk #(.AW(FB_X_W + FB_Y_W), .PX_W(tdb_pkg::PX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pix_ready    (pix_ready),
    .flush_valid  (flush_valid),
    .flush_ready  (flush_ready),
    .flush_done   (flush_done),
    .rd_cmd_valid (rd_cmd_valid),
    .rd_cmd_ready (rd_cmd_ready),
    .rd_cmd_addr  (rd_cmd_addr),
    .wr_cmd_valid (wr_cmd_valid),
    .wr_cmd_ready (wr_cmd_ready),
    .wr_cmd_addr  (wr_cmd_addr),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .wr_last      (wr_last)
);

// File: tb/test_tdb_tile_buffer.sv
`timescale 1ns/1ps
module test_tdb_tile_buffer;

    localparam int XW = 6;
    localparam int YW = 6;
    localparam int AW = XW + YW;
    localparam int FBN = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          pix_valid = 0, pix_ready;
    logic [3:0]    pix_x = 0, pix_y = 0;
    logic [23:0]   pix_color = 0;
    logic [7:0]    pix_alpha = 0;
    logic          flush_valid = 0, flush_ready;
    logic [XW-1:0] flush_org_x = 0;
    logic [YW-1:0] flush_org_y = 0;
    logic          flush_done;
    logic          rd_cmd_valid, rd_cmd_ready = 0;
    logic [AW-1:0] rd_cmd_addr;
    logic          rd_valid = 0;
    logic [23:0]   rd_data = 0;
    logic          wr_cmd_valid, wr_cmd_ready = 0;
    logic [AW-1:0] wr_cmd_addr;
    logic          wr_valid, wr_ready = 0;
    logic [23:0]   wr_data;
    logic          wr_last;

    tdb_tile_buffer #(.TILE_LOG2(4), .FB_X_W(XW), .FB_Y_W(YW)) i_tdb_tile_buffer (
        .clk(clk), .rst(rst),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
        .pix_color(pix_color), .pix_alpha(pix_alpha),
        .flush_valid(flush_valid), .flush_ready(flush_ready),
        .flush_org_x(flush_org_x), .flush_org_y(flush_org_y), .flush_done(flush_done),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready), .wr_cmd_addr(wr_cmd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference state
    logic [23:0] fb [FBN];
    logic [23:0] m_col [256];
    logic [7:0]  m_a [256];
    bit          m_w [256];
    bit  busy = 0, done_next = 0;
    int  org_x = 0, org_y = 0, m_row = 0;
    int  rd_left = 0, rd_base = 0, rd_beat = 0;
    int  wr_base = 0, wr_beat = 0;
    bit  hold_pending = 0;
    logic [23:0] hold_data;
    bit  hold_last;
    bit  pix_acc = 0, flush_acc = 0;
    int  r9_idx = -1;
    string blank_tag = "R4";
    int  cyc = 0;

    // Staged stimulus, applied at the next falling edge
    logic       t_pv = 0, t_fv = 0;
    logic [3:0] t_px = 0, t_py = 0;
    logic [23:0] t_pc = 0;
    logic [7:0]  t_pa = 0;
    int t_ox = 0, t_oy = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] ref_mix(input logic [23:0] s, input logic [23:0] d, input int a);
        logic [23:0] r;
        for (int c = 0; c < 3; c++) begin
            int x;
            x = int'(s[c*8 +: 8]) * a + int'(d[c*8 +: 8]) * (255 - a);
            r[c*8 +: 8] = 8'((2 * x + 255) / 510);
        end
        return r;
    endfunction

    task automatic compare_outputs();
        chk(pix_ready == !busy, "R2", "pix_ready", int'(pix_ready), int'(!busy));
        chk(flush_ready == !busy, "R2", "flush_ready", int'(flush_ready), int'(!busy));
        chk(flush_done == done_next, "R7", "flush_done", int'(flush_done), int'(done_next));
        done_next = 0;
        if (hold_pending) begin
            chk(wr_valid == 1'b1, "R10", "held wr_valid", int'(wr_valid), 1);
            chk(wr_data == hold_data && wr_last == hold_last, "R10", "held wr_data", int'(wr_data), int'(hold_data));
            hold_pending = 0;
        end
    endtask

    task automatic drive_inputs();
        rd_cmd_ready = (cyc % 3) != 0;
        wr_cmd_ready = (cyc % 4) != 1;
        wr_ready     = (cyc % 5) != 2;
        rd_valid     = (rd_left > 0) && ((cyc % 7) != 3);
        rd_data      = fb[(rd_base + rd_beat) % FBN];
        pix_valid    = t_pv;
        pix_x        = t_px;
        pix_y        = t_py;
        pix_color    = t_pc;
        pix_alpha    = t_pa;
        flush_valid  = t_fv;
        flush_org_x  = XW'(t_ox);
        flush_org_y  = YW'(t_oy);
        cyc++;
    endtask

    task automatic observe();
        pix_acc = 0;
        flush_acc = 0;
        if (pix_valid && pix_ready) begin
            int i;
            i = int'(pix_y) * 16 + int'(pix_x);
            m_col[i] = pix_color;
            m_a[i]   = pix_alpha;
            m_w[i]   = 1;
            pix_acc  = 1;
        end
        if (flush_valid && flush_ready) begin
            busy = 1;
            org_x = int'(flush_org_x);
            org_y = int'(flush_org_y);
            m_row = 0;
            flush_acc = 1;
        end
        if (rd_cmd_valid && rd_cmd_ready) begin
            int ea;
            ea = (org_y + m_row) * (1 << XW) + org_x;
            chk(int'(rd_cmd_addr) == ea, "R3", "read address", int'(rd_cmd_addr), ea);
            rd_base = ea; rd_beat = 0; rd_left = 16;
        end
        if (rd_valid) begin
            rd_beat++; rd_left--;
        end
        if (wr_cmd_valid && wr_cmd_ready) begin
            int ea;
            ea = (org_y + m_row) * (1 << XW) + org_x;
            chk(int'(wr_cmd_addr) == ea, "R3", "write address", int'(wr_cmd_addr), ea);
            chk(rd_left == 0, "R3", "reads complete before write", rd_left, 0);
            wr_base = ea; wr_beat = 0;
        end
        if (wr_valid && wr_ready) begin
            int i;
            logic [23:0] d, e;
            string tag;
            i = m_row * 16 + wr_beat;
            d = fb[wr_base + wr_beat];
            if (m_w[i]) begin
                e = ref_mix(m_col[i], d, int'(m_a[i]));
                tag = (i == r9_idx) ? "R9" : ((m_a[i] == 8'd255 || m_a[i] == 8'd0) ? "R6" : "R5");
            end else begin
                e = d;
                tag = blank_tag;
            end
            chk(wr_data == e, tag, "write beat data", int'(wr_data), int'(e));
            chk(wr_last == (wr_beat == 15), "R3", "wr_last", int'(wr_last), int'(wr_beat == 15));
            fb[wr_base + wr_beat] = e;
            wr_beat++;
            if (wr_beat == 16) begin
                m_row++;
                if (m_row == 16) begin
                    busy = 0;
                    done_next = 1;
                    for (int k = 0; k < 256; k++) m_w[k] = 0;
                end
            end
        end else if (wr_valid) begin
            hold_pending = 1;
            hold_data = wr_data;
            hold_last = wr_last;
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_outputs();
        drive_inputs();
        #1;
        observe();
        @(posedge clk);
    endtask

    task automatic send_pixel(input int x, input int y, input logic [23:0] c, input int a);
        t_pv = 1; t_px = 4'(x); t_py = 4'(y); t_pc = c; t_pa = 8'(a);
        do step(); while (!pix_acc);
        t_pv = 0;
    endtask

    task automatic run_flush(input int ox, input int oy);
        t_fv = 1; t_ox = ox; t_oy = oy;
        do step(); while (!flush_acc);
        t_fv = 0;
        do step(); while (busy);
        step();
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < FBN; i++) fb[i] = 24'((i * 32'h9E3779B1) >> 5);
        for (int i = 0; i < 256; i++) begin m_w[i] = 0; m_col[i] = 0; m_a[i] = 0; end

        // R11: outputs held in reset
        repeat (3) @(negedge clk);
        compared++;
        if (!(pix_ready && flush_ready && !flush_done && !rd_cmd_valid && !wr_cmd_valid && !wr_valid)) begin
            mismatched++;
            $display("FAIL R11 reset outputs: actual %b%b%b%b%b%b expected 110000",
                     pix_ready, flush_ready, flush_done, rd_cmd_valid, wr_cmd_valid, wr_valid);
        end
        rst = 0;
        @(posedge clk);
        step(); step();

        // R1, R5, R6: overwrite, mid alpha, extremes
        send_pixel(3, 4, 24'h102030, 200);
        send_pixel(3, 4, 24'hF0E0D0, 90);   // R1: replaces the earlier pixel
        send_pixel(0, 0, 24'hABCDEF, 255);  // R6
        send_pixel(15, 15, 24'h123456, 0);  // R6
        send_pixel(15, 0, 24'hFFFFFF, 128);
        send_pixel(0, 15, 24'h000000, 1);
        run_flush(16, 8);

        // R9: pixel and flush in the same idle cycle, R2: pixel held during flush
        t_pv = 1; t_px = 4'd7; t_py = 4'd7; t_pc = 24'h55AA33; t_pa = 8'd255;
        t_fv = 1; t_ox = 32; t_oy = 16;
        do step(); while (!flush_acc);
        chk(pix_acc == 1'b1, "R9", "pixel accepted with flush", int'(pix_acc), 1);
        r9_idx = 7 * 16 + 7;
        t_fv = 0;
        t_px = 4'd2; t_py = 4'd9; t_pc = 24'h0F0F0F; t_pa = 8'd77;
        begin
            int late;
            late = 0;
            do begin
                step();
                if (pix_acc && busy) late++;
            end while (busy);
            chk(late == 0, "R2", "pixel taken during flush", late, 0);
        end
        r9_idx = -1;
        do step(); while (!pix_acc);
        t_pv = 0;
        run_flush(32, 16);

        // R8: no new pixels, every value must come back unchanged
        blank_tag = "R8";
        run_flush(32, 16);
        blank_tag = "R4";

        // Scattered pseudo-random pixels with overdraw
        lf = 32'hACE1_2357;
        for (int n = 0; n < 90; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = lf * 32'd1103515245 + 32'd12345;
            send_pixel(int'(lf[3:0]), int'(lf[7:4]), lf[31:8], int'(lf[15:8] ^ lf[27:20]));
        end
        run_flush(48, 40);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule